// File: doc/BRIEF.md
# Hall-Sensor Adaptive Slice Timer

This block turns two hall-effect sensor outputs, mounted opposite each other on a spinning assembly, into a stream of angular slice events. Each falling edge of either sensor marks an exact half-turn reference. The block counts clock cycles between consecutive references. It right-shifts that count by the log2 of the slices per half-turn, and uses the result as the slice period for the half-turn that follows. The slice timing therefore tracks motor speed changes without any prior knowledge of the speed, and with no divider.

Downstream logic sees three things. A one-cycle half-turn pulse marks each reference. A one-cycle slice pulse marks each move to a new slice. A slice index counts through the revolution, with the first half-turn after sensor A and the second half-turn after sensor B. The last measured half-turn length is also held on an output, so a host can derive the motor speed from it.

Top module: `hall_slice_timer`

## Requirements
- R1: Every falling edge of either sensor input, after a two-flop synchronizer, produces exactly one single-cycle `half_turn_pulse`. Consecutive pulses are spaced by exactly as many cycles as the corresponding input edges.
- R2: In the cycle in which `half_turn_pulse` is high, `halfturn_period` shows the number of cycles since the previous half-turn pulse. The value is held until the next pulse. It stays 0 until a second reference has been seen.
- R3: With P = `halfturn_period` >> SLICE_LOG2, taken at a half-turn pulse, `slice_pulse` is high in that same cycle and then every P cycles after it.
- R4: A reference from sensor A (`hall_a_i`) sets `slice_idx` to 0, and one from sensor B sets it to 2^SLICE_LOG2. If both sensors fall in the same cycle, A wins. The index advances by one with each later slice pulse, and its top bit never changes between references.
- R5: At most 2^SLICE_LOG2 slice pulses follow one reference. After the last of them, no pulse appears until the next reference.
- R6: A reference that arrives before the current slice sequence is complete cuts that sequence off. The new sequence starts in the cycle of the new half-turn pulse.
- R7: No slice pulse appears before one full half-turn has been measured after reset. None appears in a half-turn whose estimate P is zero.
- R8: If no reference arrives for 2^CNT_W-1 cycles, the cycle counter holds at its maximum. The next reference then reports that maximum as the period, and emits no slice pulses for that half-turn.
- R9: During and directly after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hall_a_i | input | 1 | Sensor A output, idle high; a falling edge is a reference for the first half-turn |
| hall_b_i | input | 1 | Sensor B output, idle high; a falling edge is a reference for the second half-turn |
| half_turn_pulse | output | 1 | One-cycle pulse per reference edge |
| slice_pulse | output | 1 | One-cycle pulse on entry to each new slice |
| slice_idx | output | SLICE_LOG2+1 | Current slice within the revolution |
| halfturn_period | output | CNT_W | Last measured half-turn length in cycles |

## Verification
The hardest case to reach from the ports is a reference that lands in the middle of a slice sequence, cutting it short. The saturated half-turn is also hard to reach, because the counter must run for thousands of idle cycles. The bench uses a small configuration, with 8 slices per half-turn and a 12-bit counter. It drives alternating sensor edges with a chosen list of gaps: speed-ups that truncate the sequence, a gap too short to yield a nonzero estimate, and one gap longer than the counter range. For every half-turn, the expected pulse times, indices and truncation counts are computed from the gap list alone.

// File: rtl/hst_pkg.sv
package hst_pkg;

    localparam int DEF_CNT_W      = 24;
    localparam int DEF_SLICE_LOG2 = 7;
    localparam int DEF_SYNC_DEPTH = 2;

    typedef enum logic {
        SRC_A = 1'b0,
        SRC_B = 1'b1
    } hall_src_e;

    typedef struct packed {
        logic      hit;
        hall_src_e src;
    } ref_evt_t;

    // Sensor A has priority when both fall in the same cycle.
    function automatic ref_evt_t merge_refs(input logic fall_a, input logic fall_b);
        ref_evt_t ev;
        ev.hit = fall_a | fall_b;
        ev.src = fall_a ? SRC_A : SRC_B;
        return ev;
    endfunction

endpackage

// File: rtl/hst_fall_detect.sv
module hst_fall_detect #(
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sens_i,
    output logic fall_o
);

    logic [SYNC_DEPTH-1:0] sync_q;
    logic                  prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_DEPTH-2:0], sens_i};
            prev_q <= sync_q[SYNC_DEPTH-1];
        end
    end

    assign fall_o = prev_q & ~sync_q[SYNC_DEPTH-1];

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o); // R1

endmodule

// File: rtl/hst_half_meter.sv
module hst_half_meter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             sat_o,
    output logic             armed_o,
    output logic [CNT_W-1:0] period_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] period_q;
    logic             armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            period_q <= '0;
            armed_q  <= 1'b0;
        end else if (ref_i) begin
            cnt_q   <= CNT_W'(1);
            armed_q <= 1'b1;
            if (armed_q)
                period_q <= cnt_q;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt_o    = cnt_q;
    assign sat_o    = (cnt_q == CNT_MAX);
    assign armed_o  = armed_q;
    assign period_o = period_q;

    AST_PERIOD_HELD: assert property (@(posedge clk) disable iff (rst)
        !ref_i |=> $stable(period_q)); // R2
    AST_CNT_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && !ref_i) |=> (cnt_q == CNT_MAX)); // R8

endmodule

// File: rtl/hst_slice_seq.sv
module hst_slice_seq
    import hst_pkg::*;
#(
    parameter int CNT_W      = 24,
    parameter int SLICE_LOG2 = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  ref_evt_t            ref_i,
    input  logic [CNT_W-1:0]    cnt_i,
    input  logic                sat_i,
    input  logic                armed_i,
    output logic                half_turn_o,
    output logic                slice_pulse_o,
    output logic [SLICE_LOG2:0] slice_idx_o
);

    localparam int IDX_W = SLICE_LOG2 + 1;

    logic [CNT_W-1:0] est_new;
    logic             est_ok;
    logic [CNT_W-1:0] est_q;
    logic [CNT_W-1:0] down_q;
    logic [IDX_W-1:0] idx_q;
    logic             run_q;
    logic             ht_q;
    logic             sp_q;

    assign est_new = cnt_i >> SLICE_LOG2;
    assign est_ok  = armed_i && !sat_i && (est_new != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            est_q  <= '0;
            down_q <= '0;
            idx_q  <= '0;
            run_q  <= 1'b0;
            ht_q   <= 1'b0;
            sp_q   <= 1'b0;
        end else begin
            ht_q <= ref_i.hit;
            sp_q <= 1'b0;
            if (ref_i.hit) begin
                idx_q  <= {ref_i.src == SRC_B, {SLICE_LOG2{1'b0}}};
                est_q  <= est_new;
                down_q <= est_new;
                run_q  <= est_ok;
                sp_q   <= est_ok;
            end else if (run_q) begin
                if (sat_i) begin
                    run_q <= 1'b0;
                end else if (down_q == CNT_W'(1)) begin
                    if (idx_q[SLICE_LOG2-1:0] == {SLICE_LOG2{1'b1}}) begin
                        run_q <= 1'b0;
                    end else begin
                        idx_q  <= idx_q + IDX_W'(1);
                        sp_q   <= 1'b1;
                        down_q <= est_q;
                    end
                end else begin
                    down_q <= down_q - CNT_W'(1);
                end
            end
        end
    end

    assign half_turn_o   = ht_q;
    assign slice_pulse_o = sp_q;
    assign slice_idx_o   = idx_q;

    AST_NO_PULSE_UNARMED: assert property (@(posedge clk) disable iff (rst)
        !armed_i |-> !sp_q); // R7
    AST_IDX_BASE: assert property (@(posedge clk) disable iff (rst)
        ref_i.hit |=> (idx_q[SLICE_LOG2-1:0] == '0)); // R4
    AST_HALF_BIT_STABLE: assert property (@(posedge clk) disable iff (rst)
        !ref_i.hit |=> $stable(idx_q[SLICE_LOG2])); // R4

endmodule

// File: rtl/hall_slice_timer.sv
module hall_slice_timer
    import hst_pkg::*;
#(
    parameter int CNT_W      = DEF_CNT_W,
    parameter int SLICE_LOG2 = DEF_SLICE_LOG2,
    parameter int SYNC_DEPTH = DEF_SYNC_DEPTH
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hall_a_i,
    input  logic                hall_b_i,
    output logic                half_turn_pulse,
    output logic                slice_pulse,
    output logic [SLICE_LOG2:0] slice_idx,
    output logic [CNT_W-1:0]    halfturn_period
);

    localparam int N_SENS = 2;

    logic [N_SENS-1:0] sens;
    logic [N_SENS-1:0] fall;
    ref_evt_t          ref_ev;
    logic [CNT_W-1:0]  cnt;
    logic              sat;
    logic              armed;

    assign sens = {hall_b_i, hall_a_i};

    for (genvar g = 0; g < N_SENS; g++) begin : g_sens
        hst_fall_detect #(
            .SYNC_DEPTH(SYNC_DEPTH)
        ) fall_i (
            .clk   (clk),
            .rst   (rst),
            .sens_i(sens[g]),
            .fall_o(fall[g])
        );
    end

    assign ref_ev = merge_refs(fall[0], fall[1]);

    hst_half_meter #(
        .CNT_W(CNT_W)
    ) meter_i (
        .clk     (clk),
        .rst     (rst),
        .ref_i   (ref_ev.hit),
        .cnt_o   (cnt),
        .sat_o   (sat),
        .armed_o (armed),
        .period_o(halfturn_period)
    );

    hst_slice_seq #(
        .CNT_W     (CNT_W),
        .SLICE_LOG2(SLICE_LOG2)
    ) seq_i (
        .clk          (clk),
        .rst          (rst),
        .ref_i        (ref_ev),
        .cnt_i        (cnt),
        .sat_i        (sat),
        .armed_i      (armed),
        .half_turn_o  (half_turn_pulse),
        .slice_pulse_o(slice_pulse),
        .slice_idx_o  (slice_idx)
    );

    AST_HT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        half_turn_pulse |=> !half_turn_pulse); // R1

endmodule

// File: tb/hall_slice_timer_tb_top.sv
module hall_slice_timer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int L     = 3;
    localparam int S     = 1 << L;
    localparam int CW    = 12;
    localparam int MAXC  = (1 << CW) - 1;
    localparam int N     = 14;
    localparam int WDOG  = 50000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hall_a = 1'b1;
    logic hall_b = 1'b1;
    logic ht, sp;
    logic [L:0] idx;
    logic [CW-1:0] per;

    int gaps [N] = '{100, 200, 200, 163, 300, 90, 400, 7, 240, 5000, 160, 160, 129, 64};

    int errors = 0, checks = 0;
    int cyc = 0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;

    int ht_seen = 0, last_ht = 0;
    int n_left = 0, next_c = 0, nidx = 0, per_p = 0;
    int trunc_seen = 0, pulses_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hall_slice_timer #(.CNT_W(CW), .SLICE_LOG2(L), .SYNC_DEPTH(2)) dut_i (
        .clk(clk), .rst(rst), .hall_a_i(hall_a), .hall_b_i(hall_b),
        .half_turn_pulse(ht), .slice_pulse(sp), .slice_idx(idx), .halfturn_period(per)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Output monitor, sampling on the falling clock edge
    always @(negedge clk) begin
        if (mon_on) begin
            if (ht) begin
                int k, exp_per, p;
                bit valid;
                k = ht_seen;
                if (k >= N) begin
                    chk(1'b0, "R1", k, N - 1);
                end else begin
                    if (k >= 1) chk(cyc - last_ht == gaps[k], "R1", cyc - last_ht, gaps[k]);
                    exp_per = (k == 0) ? 0 : ((gaps[k] > MAXC) ? MAXC : gaps[k]);
                    if (k >= 1 && gaps[k] > MAXC) chk(int'(per) == exp_per, "R8", per, exp_per);
                    else chk(int'(per) == exp_per, "R2", per, exp_per);
                    chk(int'(idx) == (k % 2) * S, "R4", idx, (k % 2) * S);
                    if (n_left > 0) trunc_seen++;
                    p = gaps[k] >> L;
                    valid = (k >= 1) && (gaps[k] < MAXC) && (p > 0);
                    n_left = valid ? S : 0;
                    per_p  = p;
                    next_c = cyc;
                    nidx   = (k % 2) * S;
                end
                last_ht = cyc;
                ht_seen++;
            end
            if (sp) begin
                pulses_seen++;
                if (n_left > 0 && cyc == next_c) begin
                    chk(int'(idx) == nidx, "R4", idx, nidx);
                    nidx++;
                    next_c += per_p;
                    n_left--;
                end else begin
                    // unexpected pulse: before first measurement (R7), past the last slice (R5)
                    chk(1'b0, "R5/R7", cyc, next_c);
                end
            end else if (n_left > 0 && cyc >= next_c) begin
                chk(1'b0, "R3", cyc, next_c);
                n_left = 0;
            end
        end
    end

    initial begin
        int exp_trunc, exp_pulses;
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R9: outputs during reset
        chk(ht == 1'b0 && sp == 1'b0, "R9", {ht, sp}, 0);
        chk(idx == '0, "R9", idx, 0);
        chk(per == '0, "R9", per, 0);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk(ht == 1'b0 && sp == 1'b0 && idx == '0 && per == '0, "R9", {ht, sp}, 0);
        mon_on = 1'b1;
        for (int k = 0; k < N; k++) begin
            repeat (gaps[k] - 3) @(posedge clk);
            #1;
            if (k % 2 == 0) hall_a = 1'b0; else hall_b = 1'b0;
            repeat (3) @(posedge clk);
            #1;
            hall_a = 1'b1;
            hall_b = 1'b1;
        end
        repeat (300) @(posedge clk);
        @(negedge clk);
        chk(ht_seen == N, "R1", ht_seen, N);
        exp_trunc = 0;
        exp_pulses = 0;
        for (int k = 1; k < N; k++) begin
            int p;
            p = gaps[k] >> L;
            if (gaps[k] < MAXC && p > 0) begin
                if (k == N - 1) exp_pulses += S;
                else begin
                    int c;
                    c = (gaps[k+1] + p - 1) / p;
                    exp_pulses += (c < S) ? c : S;
                    if ((S - 1) * p >= gaps[k+1]) exp_trunc++;
                end
            end
        end
        chk(trunc_seen == exp_trunc, "R6", trunc_seen, exp_trunc);
        chk(pulses_seen == exp_pulses, "R3", pulses_seen, exp_pulses);
        chk(n_left == 0, "R5", n_left, 0);
        summary();
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        chk(1'b0, "watchdog", cyc, WDOG);
        summary();
    end

endmodule